// File: doc/BRIEF.md
# Register Rename Unit with Committed Map

This block converts architectural register names into physical register tags for an out-of-order core. It holds two mapping tables and a pool of free tags. The speculative map is read and written at rename. It gives each source the tag of the youngest older writer that is still in flight. The committed map changes only when a writing instruction retires. Retirement is a pointer update: the committed entry is set to the retiring instruction's tag, and no register data moves.

A rename request is a valid/ready transfer. The upstream stage holds `ren_valid` and its fields steady until it sees `ren_ready` high in the same cycle. A transfer with `ren_valid` low, or with `ren_ready` low, has no effect. The result tags are combinational outputs, valid in the cycle the transfer completes. Retire notifications and the flush are plain control pins. They are always accepted and cannot be held off. On an exception flush, the whole committed map is copied into the speculative map in one cycle. The free pool is rebuilt from the committed map in the same cycle, which throws away every tag held by younger in-flight work.

Top module: `rn_rename_top`

## Requirements
- R1: After reset, both maps send architectural register i to physical tag i. The free pool holds tags NUM_ARCH to NUM_PHYS-1, and the lowest-numbered free tag is always the one handed out first.
- R2: A completed rename with `ren_wr`=1 returns in `ren_pdst` the lowest free tag and in `ren_pold` the speculative entry for `ren_dst` before the update. From the next cycle the speculative entry for `ren_dst` holds `ren_pdst`, and that tag has left the pool.
- R3: `ren_psrc0`/`ren_psrc1` are the speculative entries of the sources before the same request's own destination write. A later consumer therefore sees the tag of the most recent earlier producer.
- R4: `ren_ready` is low while `ren_wr`=1 and the pool is empty. A request with `ren_wr`=0 needs no tag and is not stalled by an empty pool.
- R5: A retire with `ret_valid`=1 sets the committed entry for `ret_dst` to `ret_ptag` from the next cycle. The tag that entry held before goes back to the free pool.
- R6: A cycle with `flush`=1 loads every speculative entry from the matching committed entry, effective the next cycle.
- R7: On a flush, the pool is rebuilt to hold exactly the tags that the committed map does not name.
- R8: A flush takes priority. `ren_ready` is low during it, and a retire presented in the same cycle is dropped, leaving the committed map unchanged.
- R9: Outside a flush, the speculative map changes only through a completed write rename.
- R10: A tag handed out at rename is never one that the committed map currently names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Exception recovery: restore speculative map from committed map |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Rename request can be accepted this cycle |
| ren_wr | input | 1 | Request writes a destination register |
| ren_src0 | input | clog2(NUM_ARCH) | First source architectural index |
| ren_src1 | input | clog2(NUM_ARCH) | Second source architectural index |
| ren_dst | input | clog2(NUM_ARCH) | Destination architectural index |
| ren_psrc0 | output | clog2(NUM_PHYS) | Physical tag of first source |
| ren_psrc1 | output | clog2(NUM_PHYS) | Physical tag of second source |
| ren_pdst | output | clog2(NUM_PHYS) | Newly allocated destination tag |
| ren_pold | output | clog2(NUM_PHYS) | Previous speculative tag of the destination |
| ret_valid | input | 1 | A writing instruction retires |
| ret_dst | input | clog2(NUM_ARCH) | Architectural destination of the retiring instruction |
| ret_ptag | input | clog2(NUM_PHYS) | Physical tag allocated to the retiring instruction |

## Verification
The properties assume that retirement follows program order, so each `ret_ptag` is the tag given out at rename to the oldest writer still in flight for `ret_dst`, and that nothing retires after a flush has discarded it. Without this, the pool and the committed map could overlap, and the rule that a fresh tag is never committed would not hold. The bench keeps its own list of in-flight writers in rename order. It retires only from the head of that list and clears the list whenever it raises a flush, so every stimulus it generates meets this assumption.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int RN_ARCH_REGS = 8;
  parameter int RN_PHYS_REGS = 32;
endpackage

// File: rtl/rn_spec_map.sv
module rn_spec_map #(
  parameter int NA = 8,
  parameter int TW = 5,
  localparam int AW = $clog2(NA)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   restore,
  input  logic [NA-1:0][TW-1:0]  restore_tbl,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_arch,
  input  logic [TW-1:0]          wr_tag,
  input  logic [AW-1:0]          rd0_arch,
  input  logic [AW-1:0]          rd1_arch,
  output logic [TW-1:0]          rd0_tag,
  output logic [TW-1:0]          rd1_tag,
  output logic [TW-1:0]          old_tag,
  output logic [NA-1:0][TW-1:0]  tbl_o
);
  logic [NA-1:0][TW-1:0] tbl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) tbl_q[i] <= TW'(i);
    end else if (restore) begin
      tbl_q <= restore_tbl;
    end else if (wr_en) begin
      tbl_q[wr_arch] <= wr_tag;
    end
  end

  assign rd0_tag = tbl_q[rd0_arch];
  assign rd1_tag = tbl_q[rd1_arch];
  assign old_tag = tbl_q[wr_arch];
  assign tbl_o   = tbl_q;
endmodule

// File: rtl/rn_commit_map.sv
module rn_commit_map #(
  parameter int NA = 8,
  parameter int NP = 32,
  localparam int TW = $clog2(NP),
  localparam int AW = $clog2(NA)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd_en,
  input  logic [AW-1:0]          upd_arch,
  input  logic [TW-1:0]          upd_tag,
  output logic [TW-1:0]          prev_tag,
  output logic [NA-1:0][TW-1:0]  tbl_o,
  output logic [NP-1:0]          used_mask
);
  logic [NA-1:0][TW-1:0] tbl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) tbl_q[i] <= TW'(i);
    end else if (upd_en) begin
      tbl_q[upd_arch] <= upd_tag;
    end
  end

  always_comb begin
    used_mask = '0;
    for (int i = 0; i < NA; i++) used_mask[tbl_q[i]] = 1'b1;
  end

  assign prev_tag = tbl_q[upd_arch];
  assign tbl_o    = tbl_q;
endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
  parameter int NA = 8,
  parameter int NP = 32,
  localparam int TW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rebuild,
  input  logic [NP-1:0] used_mask,
  input  logic          take,
  input  logic          give,
  input  logic [TW-1:0] give_tag,
  output logic          avail,
  output logic [TW-1:0] next_tag
);
  logic [NP-1:0] free_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) free_q[i] <= (i >= NA);
    end else if (rebuild) begin
      free_q <= ~used_mask;
    end else begin
      if (take) free_q[next_tag] <= 1'b0;
      if (give) free_q[give_tag] <= 1'b1;
    end
  end

  // lowest-numbered free tag wins
  always_comb begin
    next_tag = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (free_q[i]) next_tag = TW'(i);
    end
  end

  assign avail = |free_q;
endmodule

// File: rtl/rn_rename_top.sv
module rn_rename_top #(
  parameter int NUM_ARCH = rn_pkg::RN_ARCH_REGS,
  parameter int NUM_PHYS = rn_pkg::RN_PHYS_REGS,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int TW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic          ren_wr,
  input  logic [AW-1:0] ren_src0,
  input  logic [AW-1:0] ren_src1,
  input  logic [AW-1:0] ren_dst,
  output logic [TW-1:0] ren_psrc0,
  output logic [TW-1:0] ren_psrc1,
  output logic [TW-1:0] ren_pdst,
  output logic [TW-1:0] ren_pold,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_dst,
  input  logic [TW-1:0] ret_ptag
);
  logic                        pool_avail;
  logic                        alloc_en;
  logic                        commit_en;
  logic [TW-1:0]               commit_prev;
  logic [NUM_ARCH-1:0][TW-1:0] spec_tbl;
  logic [NUM_ARCH-1:0][TW-1:0] ret_tbl;
  logic [NUM_PHYS-1:0]         ret_mask;

  assign ren_ready = !flush && (!ren_wr || pool_avail);
  assign alloc_en  = ren_valid && ren_ready && ren_wr;
  assign commit_en = ret_valid && !flush;

  rn_spec_map #(.NA(NUM_ARCH), .TW(TW)) u_spec (
    .clk(clk), .rst_n(rst_n),
    .restore(flush), .restore_tbl(ret_tbl),
    .wr_en(alloc_en), .wr_arch(ren_dst), .wr_tag(ren_pdst),
    .rd0_arch(ren_src0), .rd1_arch(ren_src1),
    .rd0_tag(ren_psrc0), .rd1_tag(ren_psrc1),
    .old_tag(ren_pold), .tbl_o(spec_tbl)
  );

  rn_commit_map #(.NA(NUM_ARCH), .NP(NUM_PHYS)) u_commit (
    .clk(clk), .rst_n(rst_n),
    .upd_en(commit_en), .upd_arch(ret_dst), .upd_tag(ret_ptag),
    .prev_tag(commit_prev), .tbl_o(ret_tbl), .used_mask(ret_mask)
  );

  rn_free_pool #(.NA(NUM_ARCH), .NP(NUM_PHYS)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .rebuild(flush), .used_mask(ret_mask),
    .take(alloc_en), .give(commit_en), .give_tag(commit_prev),
    .avail(pool_avail), .next_tag(ren_pdst)
  );
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
  parameter int NA = 8,
  parameter int NP = 32,
  localparam int AW = $clog2(NA),
  localparam int TW = $clog2(NP)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic                  ren_valid,
  input logic                  ren_ready,
  input logic                  ren_wr,
  input logic [AW-1:0]         ren_dst,
  input logic [TW-1:0]         ren_pdst,
  input logic                  ret_valid,
  input logic [AW-1:0]         ret_dst,
  input logic [TW-1:0]         ret_ptag,
  input logic                  pool_avail,
  input logic [NA-1:0][TW-1:0] spec_tbl,
  input logic [NA-1:0][TW-1:0] ret_tbl,
  input logic [NP-1:0]         ret_mask
);
  AST_EMPTY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_wr && !pool_avail) |-> !ren_ready); // R4
  AST_MAP_TAKES_PDST: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready && ren_wr) |=> spec_tbl[$past(ren_dst)] == $past(ren_pdst)); // R2
  AST_RETIRE_POINTER: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !flush) |=> ret_tbl[$past(ret_dst)] == $past(ret_ptag)); // R5
  AST_FLUSH_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> spec_tbl == $past(ret_tbl)); // R6
  AST_FLUSH_DROPS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> $stable(ret_tbl)); // R8
  AST_SPEC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !(ren_valid && ren_ready && ren_wr)) |=> $stable(spec_tbl)); // R9
  AST_FRESH_UNCOMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready && ren_wr) |-> !ret_mask[ren_pdst]); // R10
endmodule

bind rn_rename_top rn_rename_chk #(.NA(NUM_ARCH), .NP(NUM_PHYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .ren_valid(ren_valid), .ren_ready(ren_ready), .ren_wr(ren_wr),
  .ren_dst(ren_dst), .ren_pdst(ren_pdst),
  .ret_valid(ret_valid), .ret_dst(ret_dst), .ret_ptag(ret_ptag),
  .pool_avail(pool_avail), .spec_tbl(spec_tbl), .ret_tbl(ret_tbl),
  .ret_mask(ret_mask)
);

// File: tb/test_rn_rename_top.sv
`timescale 1ns/1ps
module test_rn_rename_top;
  localparam int NA = 8;
  localparam int NP = 32;
  localparam int AW = $clog2(NA);
  localparam int TW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic ren_valid = 1'b0, ren_wr = 1'b0;
  logic [AW-1:0] ren_src0 = '0, ren_src1 = '0, ren_dst = '0;
  logic ren_ready;
  logic [TW-1:0] ren_psrc0, ren_psrc1, ren_pdst, ren_pold;
  logic ret_valid = 1'b0;
  logic [AW-1:0] ret_dst = '0;
  logic [TW-1:0] ret_ptag = '0;

  always #2.5 clk = ~clk;

  rn_rename_top #(.NUM_ARCH(NA), .NUM_PHYS(NP)) i_rn_rename_top (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ren_valid(ren_valid), .ren_ready(ren_ready), .ren_wr(ren_wr),
    .ren_src0(ren_src0), .ren_src1(ren_src1), .ren_dst(ren_dst),
    .ren_psrc0(ren_psrc0), .ren_psrc1(ren_psrc1),
    .ren_pdst(ren_pdst), .ren_pold(ren_pold),
    .ret_valid(ret_valid), .ret_dst(ret_dst), .ret_ptag(ret_ptag)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model
  int  m_spec[NA];
  int  m_rrat[NA];
  bit  m_free[NP];
  int  fl_dst[$];
  int  fl_tag[$];

  typedef struct { bit rdy; bit wr; int s0; int s1; int pd; int po; } exp_t;
  exp_t exp_q[$];

  function automatic int lowest_free();
    for (int i = 0; i < NP; i++) if (m_free[i]) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NA; i++) begin m_spec[i] = i; m_rrat[i] = i; end
    for (int i = 0; i < NP; i++) m_free[i] = (i >= NA);   // R1
    fl_dst.delete(); fl_tag.delete();
  endtask

  // driver: one cycle of stimulus, expectation pushed to the scoreboard
  task automatic step(input bit rv, input bit wr, input int s0, input int s1,
                      input int d, input bit tv, input bit fl);
    exp_t e;
    int lf;
    bit do_ret;
    int rd, rt;
    @(posedge clk); #1;
    do_ret = tv && (fl_dst.size() > 0);
    rd = 0; rt = 0;
    if (do_ret) begin rd = fl_dst[0]; rt = fl_tag[0]; end
    lf = lowest_free();
    e.wr  = wr;
    e.rdy = !fl && (!wr || lf >= 0);
    e.s0  = m_spec[s0];
    e.s1  = m_spec[s1];
    e.pd  = lf;
    e.po  = m_spec[d];
    flush     = fl;
    ren_valid = rv; ren_wr = wr;
    ren_src0  = AW'(s0); ren_src1 = AW'(s1); ren_dst = AW'(d);
    ret_valid = do_ret; ret_dst = AW'(rd); ret_ptag = TW'(rt);
    if (rv) exp_q.push_back(e);
    if (fl) begin
      for (int i = 0; i < NA; i++) m_spec[i] = m_rrat[i];        // R6
      for (int i = 0; i < NP; i++) m_free[i] = 1'b1;
      for (int i = 0; i < NA; i++) m_free[m_rrat[i]] = 1'b0;     // R7
      fl_dst.delete(); fl_tag.delete();                          // R8 retire dropped
    end else begin
      if (do_ret) begin
        void'(fl_dst.pop_front()); void'(fl_tag.pop_front());
      end
      if (rv && e.rdy && wr) begin
        m_spec[d] = lf; m_free[lf] = 1'b0;
        fl_dst.push_back(d); fl_tag.push_back(lf);
      end
      if (do_ret) begin
        m_free[m_rrat[rd]] = 1'b1;                               // R5
        m_rrat[rd] = rt;
      end
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    flush = 0; ren_valid = 0; ren_wr = 0; ret_valid = 0;
  endtask

  // monitor: compare every presented request against the scoreboard
  always @(negedge clk) begin
    if (rst_n && ren_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 scoreboard empty", 0, 1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(ren_ready == e.rdy, "R4/R8 ren_ready", int'(ren_ready), int'(e.rdy));
        if (e.rdy) begin
          chk(int'(ren_psrc0) == e.s0, "R3 psrc0", int'(ren_psrc0), e.s0);
          chk(int'(ren_psrc1) == e.s1, "R3 psrc1", int'(ren_psrc1), e.s1);
          if (e.wr) begin
            chk(int'(ren_pdst) == e.pd, "R2 pdst", int'(ren_pdst), e.pd);
            chk(int'(ren_pold) == e.po, "R2 pold", int'(ren_pold), e.po);
          end
        end
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    ren_wr = 1'b1;
    @(negedge clk);
    // R1: pool not empty after reset, first tag handed out is NA
    chk(ren_ready == 1'b1, "R1 ready after reset", int'(ren_ready), 1);
    chk(int'(ren_pdst) == NA, "R1 first free tag", int'(ren_pdst), NA);
    ren_wr = 1'b0;

    // R1 identity read, R3 same-cycle ordering (src reads pre-write value)
    step(1, 1, 3, 5, 3, 0, 0);
    // R3 producer chain: multiply then add reading it
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 3, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    // R5 retire oldest writers, returning old committed tags
    step(0, 0, 0, 0, 0, 1, 0);
    step(1, 1, 2, 3, 2, 1, 0);
    step(1, 0, 3, 0, 0, 0, 0);
    // R6/R7 flush then read committed tags and reallocate
    step(0, 0, 0, 0, 0, 0, 1);
    step(1, 1, 0, 3, 4, 0, 0);
    step(1, 1, 4, 0, 5, 0, 0);
    // R8 flush with rename and retire in the same cycle
    step(1, 1, 4, 5, 6, 1, 1);
    step(1, 0, 4, 5, 0, 0, 0);

    // R4 exhaust pool: writes without retire until stall
    for (int k = 0; k < NP; k++) step(1, 1, k % NA, (k + 1) % NA, k % NA, 0, 0);
    // R4 non-writing request passes with empty pool
    step(1, 0, 1, 2, 0, 0, 0);
    // R5 one retire refills; next write uses that tag
    step(1, 1, 1, 1, 1, 1, 0);
    step(1, 1, 2, 2, 2, 0, 0);
    // R9 valid low: no effect, then read back
    step(0, 1, 0, 0, 7, 0, 0);
    step(1, 0, 7, 6, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);

    // mixed random traffic, R10 checked by the bound properties
    for (int n = 0; n < 3000; n++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0,
           $urandom_range(0, NA - 1), $urandom_range(0, NA - 1),
           $urandom_range(0, NA - 1), $urandom_range(0, 2) != 0,
           $urandom_range(0, 60) == 0);
    end
    idle();
    idle();
    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule